// File: doc/BRIEF.md
# Thread-to-Core Mapping Table

This block keeps, for one cluster of cores that share a compute fabric, a small associative table with one entry per core. Each entry names the thread and the application now running on that core. When a producer wants to send work to a consumer thread, it presents the consumer's thread and application pair. In the same cycle the table returns the core that hosts that pair, which is where the result must be delivered. If the pair is not resident, the issue is refused, so a producer cannot fill the fabric with work for an absent consumer.

Every entry also counts the instructions that are still in flight towards its core. The count rises when an issue is accepted and falls when the fabric reports a completion for that core. A context switch-out of a core uses a level request and a level grant. The grant is held back until the core's in-flight count is zero. While the request waits, new work aimed at that core is stalled. Once the grant is given, the entry becomes invalid until software writes a new thread/application pair into it.

Top module: `mapTable`

## Requirements
- R1: After reset every entry is invalid, every in-flight count is zero and every grant is low, so any issue request gives a miss.
- R2: An update writes the thread and application ID into the entry selected by updCore and makes it valid from the next cycle. A later issue naming that pair is accepted in the same cycle, with issueCore equal to that entry's index.
- R3: An issue whose pair matches no valid entry raises issueMiss and keeps issueAccept low in the same cycle, and it does not change any count.
- R4: A hit requires both the thread ID and the application ID to match. A matching thread ID paired with a different application ID is a miss.
- R5: When two valid entries hold the same pair, the lowest-numbered entry is selected.
- R6: An accepted issue adds one to the target core's count and a completion subtracts one. Both in the same cycle for the same core leave the count unchanged. A completion for a core whose count is zero is ignored.
- R7: When a core's count is at its limit of 24, an issue to it stalls (issueAccept and issueMiss both low) until a completion frees a slot.
- R8: A switch-out request for a core whose count is zero raises that core's grant at the next clock edge.
- R9: While a request waits on a nonzero count, issues to that core stall. The grant rises at the clock edge after the edge at which the count reaches zero.
- R10: Once granted, the entry is invalid and issues naming its old pair miss, until an update writes a pair into it again.
- R11: A grant stays high while its request is held and falls at the edge after the request drops. Requests and grants on one core do not affect issues to the other cores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| updValid | input | 1 | Write a new pair into one entry |
| updCore | input | 2 | Entry (core index) to write |
| updThread | input | 8 | Thread ID to store |
| updApp | input | 8 | Application ID to store |
| issueValid | input | 1 | Issue request present |
| issueThread | input | 8 | Destination thread ID |
| issueApp | input | 8 | Destination application ID |
| issueAccept | output | 1 | Issue taken this cycle |
| issueMiss | output | 1 | Destination pair not resident |
| issueCore | output | 2 | Core hosting the destination (valid with issueAccept) |
| cmplValid | input | 1 | One in-flight instruction completed |
| cmplCore | input | 2 | Core the completed instruction was bound for |
| swReq | input | 4 | Per-core switch-out request (level) |
| swGrant | output | 4 | Per-core switch-out grant (level) |

## Verification
The bench fills one core to its in-flight limit and checks the issue that is refused there. It then moves the count off the limit with a completion that arrives in the same cycle as an accepted issue. A counter that mishandled the collision would either refuse the next issue or accept one too many. It drains a waiting core one completion at a time and samples the grant exactly one cycle after the count reaches zero, which exposes a grant that is early, late or never given. A completion sent to an idle core catches a counter that wraps below zero, because the table would then stall that core and never grant its switch-out. Entries with duplicate pairs, an application mismatch and a lookup of a switched-out pair cover the associative match.

// File: rtl/mapTablePkg.sv
package mapTablePkg;
  localparam int unsigned NumCores = 4;
  localparam int unsigned CoreW    = $clog2(NumCores);

  typedef logic [NumCores-1:0] coreVec_t;

  // strobes from control to the entry store, one bit per core
  typedef struct packed {
    coreVec_t wrEn;
    coreVec_t clrValid;
    coreVec_t incEn;
    coreVec_t decEn;
  } tblStrobe_t;
endpackage

// File: rtl/mapTableStore.sv
module mapTableStore
  import mapTablePkg::*;
#(
  parameter int unsigned IdW    = 8,
  parameter int unsigned MaxCnt = 24,
  localparam int unsigned CntW  = $clog2(MaxCnt + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  tblStrobe_t     strobe,
  input  logic [IdW-1:0] wrThread,
  input  logic [IdW-1:0] wrApp,
  input  logic [IdW-1:0] keyThread,
  input  logic [IdW-1:0] keyApp,
  output coreVec_t       hitVec,
  output coreVec_t       cntZero,
  output coreVec_t       cntFull
);
  localparam logic [CntW-1:0] CntLimit = CntW'(MaxCnt);

  for (genvar g = 0; g < NumCores; g++) begin : gEntry
    logic [IdW-1:0]  threadQ;
    logic [IdW-1:0]  appQ;
    logic            validQ;
    logic [CntW-1:0] cntQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        threadQ <= '0;
        appQ    <= '0;
        validQ  <= 1'b0;
      end else if (strobe.wrEn[g]) begin
        threadQ <= wrThread;
        appQ    <= wrApp;
        validQ  <= 1'b1;
      end else if (strobe.clrValid[g]) begin
        validQ  <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ <= '0;
      end else begin
        unique case ({strobe.incEn[g], strobe.decEn[g]})
          2'b10:   cntQ <= cntQ + 1'b1;
          2'b01:   cntQ <= cntQ - 1'b1;
          default: cntQ <= cntQ;
        endcase
      end
    end

    assign hitVec[g]  = validQ && (threadQ == keyThread) && (appQ == keyApp);
    assign cntZero[g] = (cntQ == '0);
    assign cntFull[g] = (cntQ >= CntLimit);
  end
endmodule

// File: rtl/mapTableCtrl.sv
module mapTableCtrl
  import mapTablePkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             updValid,
  input  logic [CoreW-1:0] updCore,
  input  logic             issueValid,
  input  logic             cmplValid,
  input  logic [CoreW-1:0] cmplCore,
  input  coreVec_t         swReq,
  input  coreVec_t         hitVec,
  input  coreVec_t         cntZero,
  input  coreVec_t         cntFull,
  output tblStrobe_t       strobe,
  output logic             issueAccept,
  output logic             issueMiss,
  output logic [CoreW-1:0] issueCore,
  output coreVec_t         swGrant
);
  coreVec_t         grantQ;
  coreVec_t         grantNext;
  coreVec_t         blockedVec;
  logic [CoreW-1:0] selCore;
  logic             anyHit;

  // lowest index wins among matching entries
  always_comb begin
    selCore = '0;
    for (int i = NumCores - 1; i >= 0; i--) begin
      if (hitVec[i]) selCore = CoreW'(i);
    end
  end

  assign anyHit     = |hitVec;
  assign blockedVec = swReq & ~grantQ;

  assign issueAccept = issueValid && anyHit && !blockedVec[selCore] && !cntFull[selCore];
  assign issueMiss   = issueValid && !anyHit;
  assign issueCore   = selCore;

  // a held grant stays; a new one needs a drained count
  assign grantNext = swReq & (grantQ | cntZero);

  always_ff @(posedge clk) begin
    if (!rstN) grantQ <= '0;
    else       grantQ <= grantNext;
  end

  always_comb begin
    strobe          = '0;
    strobe.wrEn     = updValid ? coreVec_t'(1) << updCore : '0;
    strobe.clrValid = grantNext & ~grantQ;
    strobe.incEn    = issueAccept ? coreVec_t'(1) << selCore : '0;
    strobe.decEn    = (cmplValid ? coreVec_t'(1) << cmplCore : '0) & ~cntZero;
  end

  assign swGrant = grantQ;
endmodule

// File: rtl/mapTable.sv
module mapTable
  import mapTablePkg::*;
#(
  parameter int unsigned IdW         = 8,
  parameter int unsigned MaxInflight = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 updValid,
  input  logic [CoreW-1:0]     updCore,
  input  logic [IdW-1:0]       updThread,
  input  logic [IdW-1:0]       updApp,
  input  logic                 issueValid,
  input  logic [IdW-1:0]       issueThread,
  input  logic [IdW-1:0]       issueApp,
  output logic                 issueAccept,
  output logic                 issueMiss,
  output logic [CoreW-1:0]     issueCore,
  input  logic                 cmplValid,
  input  logic [CoreW-1:0]     cmplCore,
  input  logic [NumCores-1:0]  swReq,
  output logic [NumCores-1:0]  swGrant
);
  tblStrobe_t strobe;
  coreVec_t   hitVec;
  coreVec_t   cntZero;
  coreVec_t   cntFull;

  mapTableStore #(.IdW(IdW), .MaxCnt(MaxInflight)) i_store (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrThread  (updThread),
    .wrApp     (updApp),
    .keyThread (issueThread),
    .keyApp    (issueApp),
    .hitVec    (hitVec),
    .cntZero   (cntZero),
    .cntFull   (cntFull)
  );

  mapTableCtrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .updValid    (updValid),
    .updCore     (updCore),
    .issueValid  (issueValid),
    .cmplValid   (cmplValid),
    .cmplCore    (cmplCore),
    .swReq       (swReq),
    .hitVec      (hitVec),
    .cntZero     (cntZero),
    .cntFull     (cntFull),
    .strobe      (strobe),
    .issueAccept (issueAccept),
    .issueMiss   (issueMiss),
    .issueCore   (issueCore),
    .swGrant     (swGrant)
  );
endmodule

// File: rtl/mapTableChk.sv
module mapTableChk
  import mapTablePkg::*;
#(
  parameter int unsigned MaxInflight = 24
) (
  input logic                clk,
  input logic                rstN,
  input logic                issueValid,
  input logic                issueAccept,
  input logic                issueMiss,
  input logic [CoreW-1:0]    issueCore,
  input logic                cmplValid,
  input logic [CoreW-1:0]    cmplCore,
  input logic [NumCores-1:0] swReq,
  input logic [NumCores-1:0] swGrant
);
  // R3
  miss_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueMiss |-> (issueValid && !issueAccept));

  for (genvar g = 0; g < NumCores; g++) begin : gCore
    int unsigned shadowCnt;
    logic        accHere;
    logic        cmplHere;

    assign accHere  = issueAccept && (issueCore == CoreW'(g));
    assign cmplHere = cmplValid && (cmplCore == CoreW'(g));

    always_ff @(posedge clk) begin
      if (!rstN)                              shadowCnt <= 0;
      else if (accHere && !cmplHere)          shadowCnt <= shadowCnt + 1;
      else if (!accHere && cmplHere && shadowCnt != 0) shadowCnt <= shadowCnt - 1;
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
      accHere |-> (shadowCnt < MaxInflight));

    // R9
    block_chk: assert property (@(posedge clk) disable iff (!rstN)
      accHere |-> !(swReq[g] && !swGrant[g]));

    // R9
    drained_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(swGrant[g]) |-> (shadowCnt == 0));

    // R8
    grant_req_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(swGrant[g]) |-> $past(swReq[g]));

    // R11
    grant_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
      !swReq[g] |=> !swGrant[g]);
  end
endmodule

bind mapTable mapTableChk #(.MaxInflight(MaxInflight)) i_mapTableChk (
  .clk         (clk),
  .rstN        (rstN),
  .issueValid  (issueValid),
  .issueAccept (issueAccept),
  .issueMiss   (issueMiss),
  .issueCore   (issueCore),
  .cmplValid   (cmplValid),
  .cmplCore    (cmplCore),
  .swReq       (swReq),
  .swGrant     (swGrant)
);

// File: tb/test_mapTable.sv
module test_mapTable;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       updValid = 1'b0;
  logic [1:0] updCore = '0;
  logic [7:0] updThread = '0;
  logic [7:0] updApp = '0;
  logic       issueValid = 1'b0;
  logic [7:0] issueThread = '0;
  logic [7:0] issueApp = '0;
  logic       issueAccept;
  logic       issueMiss;
  logic [1:0] issueCore;
  logic       cmplValid = 1'b0;
  logic [1:0] cmplCore = '0;
  logic [3:0] swReq = '0;
  logic [3:0] swGrant;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    bit         acc;
    bit         miss;
    logic [1:0] core;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];

  always #10 clk = ~clk;

  mapTable i_mapTable (
    .clk(clk), .rstN(rstN),
    .updValid(updValid), .updCore(updCore), .updThread(updThread), .updApp(updApp),
    .issueValid(issueValid), .issueThread(issueThread), .issueApp(issueApp),
    .issueAccept(issueAccept), .issueMiss(issueMiss), .issueCore(issueCore),
    .cmplValid(cmplValid), .cmplCore(cmplCore),
    .swReq(swReq), .swGrant(swGrant)
  );

  task automatic clearPulses();
    updValid   = 1'b0;
    issueValid = 1'b0;
    cmplValid  = 1'b0;
  endtask

  task automatic stepIdle();
    @(negedge clk);
    clearPulses();
  endtask

  task automatic doUpdate(input logic [1:0] core, input logic [7:0] thr, input logic [7:0] app);
    @(negedge clk);
    clearPulses();
    updValid = 1'b1; updCore = core; updThread = thr; updApp = app;
  endtask

  task automatic doCmpl(input logic [1:0] core);
    @(negedge clk);
    clearPulses();
    cmplValid = 1'b1; cmplCore = core;
  endtask

  task automatic doIssue(input logic [7:0] thr, input logic [7:0] app,
                         input bit eAcc, input bit eMiss, input logic [1:0] eCore,
                         input string tag);
    expItem_t e;
    @(negedge clk);
    clearPulses();
    issueValid = 1'b1; issueThread = thr; issueApp = app;
    e.acc = eAcc; e.miss = eMiss; e.core = eCore; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic doIssueCmpl(input logic [7:0] thr, input logic [7:0] app, input logic [1:0] cc,
                             input bit eAcc, input bit eMiss, input logic [1:0] eCore,
                             input string tag);
    expItem_t e;
    @(negedge clk);
    clearPulses();
    issueValid = 1'b1; issueThread = thr; issueApp = app;
    cmplValid = 1'b1; cmplCore = cc;
    e.acc = eAcc; e.miss = eMiss; e.core = eCore; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic checkGrant(input logic [3:0] expG, input string tag);
    #5;
    checks++;
    if (swGrant !== expG) begin
      errors++;
      $display("FAIL %s: swGrant actual %b expected %b", tag, swGrant, expG);
    end
  endtask

  // monitor: compares issue results against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (issueAccept !== e.acc || issueMiss !== e.miss ||
            (e.acc && issueCore !== e.core)) begin
          errors++;
          $display("FAIL %s: acc/miss/core actual %b/%b/%0d expected %b/%b/%0d",
                   e.tag, issueAccept, issueMiss, issueCore, e.acc, e.miss, e.core);
        end
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: run actual hung expected finish");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    stepIdle();
    checkGrant(4'b0000, "R1 grants after reset");
    doIssue(8'd1, 8'd1, 0, 1, 2'd0, "R1 lookup in empty table");

    // R2: fill entries
    doUpdate(2'd0, 8'd10, 8'd1);
    doUpdate(2'd1, 8'd20, 8'd1);
    doUpdate(2'd2, 8'd30, 8'd2);
    doUpdate(2'd3, 8'd40, 8'd3);
    doIssue(8'd20, 8'd1, 1, 0, 2'd1, "R2 hit core1");   // core1 cnt 1
    doIssue(8'd40, 8'd3, 1, 0, 2'd3, "R2 hit core3");   // core3 cnt 1
    doIssue(8'd20, 8'd2, 0, 1, 2'd0, "R4 app mismatch");
    doIssue(8'd99, 8'd1, 0, 1, 2'd0, "R3 absent thread");

    // R5: duplicate pair, lowest index wins
    doUpdate(2'd3, 8'd30, 8'd2);
    doIssue(8'd30, 8'd2, 1, 0, 2'd2, "R5 duplicate picks core2"); // core2 cnt 1
    doUpdate(2'd3, 8'd40, 8'd3);

    // R8 / R10 / R11 on idle core0
    @(negedge clk); clearPulses(); swReq[0] = 1'b1;
    stepIdle();
    checkGrant(4'b0001, "R8 immediate grant");
    doIssue(8'd10, 8'd1, 0, 1, 2'd0, "R10 switched-out pair misses");
    doIssue(8'd20, 8'd1, 1, 0, 2'd1, "R11 other core unaffected");   // core1 cnt 2
    @(negedge clk); clearPulses(); swReq[0] = 1'b0;
    stepIdle();
    checkGrant(4'b0000, "R11 grant drops after request");
    doUpdate(2'd0, 8'd11, 8'd5);
    doIssue(8'd11, 8'd5, 1, 0, 2'd0, "R10 rewritten entry hits");     // core0 cnt 1

    // R9: core1 has count 2
    @(negedge clk); clearPulses(); swReq[1] = 1'b1;
    doIssue(8'd20, 8'd1, 0, 0, 2'd1, "R9 issue blocked during drain");
    checkGrant(4'b0000, "R9 no grant with count 2");
    doIssue(8'd11, 8'd5, 1, 0, 2'd0, "R11 core0 issues during core1 drain"); // core0 cnt 2
    doCmpl(2'd1);
    doCmpl(2'd1);          // core1 reaches zero at the next edge
    stepIdle();
    checkGrant(4'b0000, "R9 grant not before count is zero");
    stepIdle();
    checkGrant(4'b0010, "R9 grant after drain");
    doIssue(8'd20, 8'd1, 0, 1, 2'd0, "R10 old pair misses after grant");
    @(negedge clk); clearPulses(); swReq[1] = 1'b0;
    doCmpl(2'd0);
    doCmpl(2'd0);          // core0 back to 0

    // R7 / R6 on core2 (count 1)
    for (int k = 0; k < 23; k++) doIssue(8'd30, 8'd2, 1, 0, 2'd2, "R7 fill core2");
    doIssue(8'd30, 8'd2, 0, 0, 2'd2, "R7 stall at limit 24");
    doCmpl(2'd2);                                                      // 23
    doIssueCmpl(8'd30, 8'd2, 2'd2, 1, 0, 2'd2, "R6 issue with completion"); // stays 23
    doIssue(8'd30, 8'd2, 1, 0, 2'd2, "R6 count unchanged by collision");    // 24
    doIssue(8'd30, 8'd2, 0, 0, 2'd2, "R7 stall again at limit");
    for (int k = 0; k < 24; k++) doCmpl(2'd2);
    @(negedge clk); clearPulses(); swReq[2] = 1'b1;
    stepIdle();
    checkGrant(4'b0100, "R6 drained count grants at once");
    @(negedge clk); clearPulses(); swReq[2] = 1'b0;

    // R6: completion at zero is ignored (core3 count 1)
    doCmpl(2'd3);           // 0
    doCmpl(2'd3);           // ignored
    doIssue(8'd40, 8'd3, 1, 0, 2'd3, "R6 no wrap below zero");   // 1
    doCmpl(2'd3);           // 0
    @(negedge clk); clearPulses(); swReq[3] = 1'b1;
    stepIdle();
    checkGrant(4'b1000, "R6 grant after ignored completion");
    @(negedge clk); clearPulses(); swReq[3] = 1'b0;
    stepIdle();
    stepIdle();
    finishRun();
  end
endmodule